// File: doc/BRIEF.md
# Single-Cycle Glitch-Rejecting Debouncer

This block filters one input bit that is already synchronous to its clock. An input change that holds for one cycle only is dropped. A change that holds for two or more cycles reaches the outputs. A four-state machine tracks the recent history of the input, and one next-state function feeds two output decoders at once.

`level_o` depends on the present state alone, so it is a clean register-to-output path. `early_o` depends on the present state and on the present input. On a rising change it goes high roughly one cycle before `level_o`, and it still rejects one-cycle pulses. A design that can accept a combinational path from `din_i` to its consumer uses `early_o`. A design that needs register-only timing uses `level_o`.

States in this note: IDLE_LO (quiet low), ARM_HI (one high sample seen), HOLD_HI (settled high), ARM_LO (one low sample seen while high).

Top module: `pulse_reject_filter`

## Requirements
- R1: While `rst_ni` is low, the machine is held in IDLE_LO, and both `level_o` and `early_o` read 0 whatever `din_i` is.
- R2: From IDLE_LO, an input of 0 keeps the machine in IDLE_LO, and an input of 1 moves it to ARM_HI at the next rising clock edge.
- R3: From ARM_HI, an input of 0 returns the machine to IDLE_LO, and an input of 1 advances it to HOLD_HI.
- R4: From HOLD_HI, an input of 1 keeps the machine there, and an input of 0 moves it to ARM_LO.
- R5: From ARM_LO, an input of 0 drops the machine to IDLE_LO, and an input of 1 returns it to HOLD_HI.
- R6: `level_o` is 1 in HOLD_HI and ARM_LO and 0 in IDLE_LO and ARM_HI, independent of `din_i`.
- R7: `early_o` is 0 in IDLE_LO and 1 in HOLD_HI for either input. In ARM_HI and ARM_LO it equals `din_i` in the same cycle.
- R8: After a run of 0s, a 1 lasting one cycle changes neither output.
- R9: After a run of 1s, a 0 lasting one cycle changes neither output.
- R10: On a sustained rise after a run of 0s, `level_o` goes high after the second clock edge that samples 1. `early_o` goes high one cycle earlier, after the first such edge, and stays high from then on.
- R11: A sustained fall after a run of 1s clears `level_o` after the second clock edge that samples 0. It clears `early_o` in the cycle after the first such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | 1 | Input bit, already synchronous to clk_i |
| level_o | output | 1 | Filtered level, decoded from state only |
| early_o | output | 1 | Filtered level, decoded from state and present input |

## Verification
The block has no parameters that alter its function, so the bench builds it in its only configuration. A bench model of the two tables predicts both outputs every cycle. The stimulus reaches every state with both input values. Directed sequences cover isolated one-cycle pulses and dropouts, back-to-back pulses, and sustained rises and falls. On the rises and falls the bench checks the one-cycle lead of `early_o` cycle by cycle.

// File: rtl/pulse_reject_pkg.sv
package pulse_reject_pkg;
  localparam int unsigned StW = 2;
  typedef enum logic [StW-1:0] {
    ST_IDLE_LO = 2'd0,
    ST_ARM_HI  = 2'd1,
    ST_HOLD_HI = 2'd2,
    ST_ARM_LO  = 2'd3
  } prf_state_e;
endpackage

// File: rtl/prf_next_state.sv
module prf_next_state
  import pulse_reject_pkg::*;
(
  input  prf_state_e cur_i,
  input  logic       din_i,
  output prf_state_e nxt_o
);
  always_comb begin
    unique case (cur_i)
      ST_IDLE_LO: nxt_o = din_i ? ST_ARM_HI  : ST_IDLE_LO;
      ST_ARM_HI:  nxt_o = din_i ? ST_HOLD_HI : ST_IDLE_LO;
      ST_HOLD_HI: nxt_o = din_i ? ST_HOLD_HI : ST_ARM_LO;
      ST_ARM_LO:  nxt_o = din_i ? ST_HOLD_HI : ST_IDLE_LO;
      default:    nxt_o = ST_IDLE_LO;
    endcase
  end
endmodule

// File: rtl/prf_state_reg.sv
module prf_state_reg
  import pulse_reject_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  prf_state_e nxt_i,
  output prf_state_e cur_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_o <= ST_IDLE_LO;
    else         cur_o <= nxt_i;
  end
endmodule

// File: rtl/prf_out_dec.sv
module prf_out_dec
  import pulse_reject_pkg::*;
(
  input  prf_state_e cur_i,
  input  logic       din_i,
  output logic       level_o,
  output logic       early_o
);
  // state-only decode
  always_comb begin
    unique case (cur_i)
      ST_HOLD_HI, ST_ARM_LO: level_o = 1'b1;
      default:               level_o = 1'b0;
    endcase
  end

  // state-plus-input decode, defined on every arc
  always_comb begin
    unique case (cur_i)
      ST_IDLE_LO: early_o = 1'b0;
      ST_ARM_HI:  early_o = din_i;
      ST_HOLD_HI: early_o = 1'b1;
      ST_ARM_LO:  early_o = din_i;
      default:    early_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pulse_reject_filter.sv
module pulse_reject_filter
  import pulse_reject_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic level_o,
  output logic early_o
);
  prf_state_e cur_q;
  prf_state_e nxt_d;

  prf_next_state u_next (
    .cur_i (cur_q),
    .din_i (din_i),
    .nxt_o (nxt_d)
  );

  prf_state_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nxt_i  (nxt_d),
    .cur_o  (cur_q)
  );

  prf_out_dec u_dec (
    .cur_i   (cur_q),
    .din_i   (din_i),
    .level_o (level_o),
    .early_o (early_o)
  );
endmodule

// File: rtl/pulse_reject_filter_chk.sv
module pulse_reject_filter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic din_i,
  input logic level_o,
  input logic early_o
);
  // R10
  level_rise_two_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(level_o) |-> ($past(din_i) && $past(din_i, 2)));

  // R11
  level_fall_two_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(level_o) |-> (!$past(din_i) && !$past(din_i, 2)));

  // R10
  early_leads_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(level_o) |-> $past(early_o));

  // R7
  early_needs_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_o |-> (din_i || level_o));

  // R8
  early_lo_glitch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(early_o) && !level_o) |=> (level_o || !early_o || din_i));
endmodule

bind pulse_reject_filter pulse_reject_filter_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .din_i   (din_i),
  .level_o (level_o),
  .early_o (early_o)
);

// File: tb/pulse_reject_filter_bench.sv
module pulse_reject_filter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic level, early;
  int checks = 0;
  int errors = 0;
  int mst = 0; // 0 idle_lo, 1 arm_hi, 2 hold_hi, 3 arm_lo
  bit done = 1'b0;

  always #10 clk = ~clk;

  pulse_reject_filter u_pulse_reject_filter (
    .clk_i (clk), .rst_ni (rst_n), .din_i (din),
    .level_o (level), .early_o (early)
  );

  function automatic int f_next(int s, logic d);
    case (s)
      0: return d ? 1 : 0;
      1: return d ? 2 : 0;
      2: return d ? 2 : 3;
      default: return d ? 2 : 0;
    endcase
  endfunction

  function automatic logic f_level(int s);
    return (s == 2 || s == 3);
  endfunction

  function automatic logic f_early(int s, logic d);
    case (s)
      0: return 1'b0;
      2: return 1'b1;
      default: return d;
    endcase
  endfunction

  task automatic chk(string req, logic act, logic exp, string nm);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, nm, act, exp);
    end
  endtask

  // drive at negedge, check mid-low phase, advance model after posedge
  task automatic step(logic v, string req);
    @(negedge clk);
    din = v;
    #3;
    chk(req, level, f_level(mst), "level_o");
    chk(req, early, f_early(mst, v), "early_o");
    @(posedge clk);
    #1;
    mst = f_next(mst, v);
  endtask

  task automatic run(logic v, int n, string req);
    for (int i = 0; i < n; i++) step(v, req);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    // R1: reset with input high
    din = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", level, 1'b0, "level_o in reset");
    chk("R1", early, 1'b0, "early_o in reset");
    @(negedge clk);
    din = 1'b0;
    rst_n = 1'b1;
    mst = 0;

    run(1'b0, 4, "R2");
    // R8: isolated high pulse
    step(1'b1, "R8");
    run(1'b0, 3, "R8");
    // R8: back-to-back one-cycle pulses
    for (int i = 0; i < 4; i++) begin
      step(1'b1, "R8");
      step(1'b0, "R8");
    end
    // R10: sustained rise, early_o leads by one cycle
    step(1'b1, "R10");
    @(negedge clk); din = 1'b1; #3;
    chk("R10", early, 1'b1, "early_o after first edge");
    chk("R10", level, 1'b0, "level_o after first edge");
    @(posedge clk); #1; mst = f_next(mst, 1'b1);
    run(1'b1, 3, "R10");
    // R9: isolated dropout
    step(1'b0, "R9");
    run(1'b1, 3, "R9");
    for (int i = 0; i < 3; i++) begin
      step(1'b0, "R9");
      step(1'b1, "R9");
    end
    // R11: sustained fall
    step(1'b0, "R11");
    step(1'b0, "R11");
    run(1'b0, 3, "R11");
    // R3/R5 arcs
    step(1'b1, "R3");
    step(1'b0, "R3");
    run(1'b1, 3, "R4");
    step(1'b0, "R5");
    step(1'b1, "R5");
    step(1'b0, "R5");
    step(1'b0, "R5");
    // random mix: R6 and R7 tables
    for (int i = 0; i < 2000; i++) begin
      logic v;
      v = ($urandom % 3) != 0 ? din : ~din;
      step(v, (i % 2) ? "R6" : "R7");
    end
    // R1: asynchronous reset mid-run
    run(1'b1, 3, "R4");
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk("R1", level, 1'b0, "level_o after async reset");
    chk("R1", early, 1'b0, "early_o after async reset");
    @(negedge clk);
    din = 1'b0;
    rst_n = 1'b1;
    mst = 0;
    run(1'b0, 2, "R2");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule